// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer Controller

This block is a watchdog timer controlled through a single 8-bit register on a plain write/read bus. Only certain byte values written to the register act as commands. One byte arms the timer and restarts its count. A pair of bytes switches the timer off, but only when the two writes land close together in time. Another byte latches a lockout that makes the switch-off pair useless until the next reset. A write with the top bit clear sets the timeout selector in the low three bits. The period is a power of four.

If software does not restart the count in time, the block raises a reset request for one clock. Its own state goes back to the reset values on that same edge. A read returns the running flag and the programmed selector. Firmware arms the timer during initialisation and optionally locks it. After that it writes the restart byte periodically.

Top module: `wdt_keyseq_top`

## Requirements
- R1: A write of 0xA5 sets the timer running (read bit 4 = 1) and restarts the count from zero. It also loads the current selector as the active period.
- R2: A write of 0xDE followed by 0xAD stops the timer (read bit 4 = 0). This happens only if the 0xAD write is captured 1 to 4 clocks after the 0xDE write. With a gap of 5 or more, the pair has no effect. Any other write in between cancels the pending pair. A 0xAD write with no pending 0xDE has no effect.
- R3: A write of 0xFF sets a lockout. While it is set, the 0xDE/0xAD pair never stops the timer. The lockout clears only on reset, including the reset caused by expiry. Writing 0xFF does not restart the count and does not start the timer.
- R4: While running, the reset request `wdt_rst_req` rises exactly 4^(3+N) clocks after the restarting edge, where N is the active selector. It is high for exactly one clock.
- R5: A write with bit 7 = 0 loads bits [2:0] into the selector. A write with bit 7 = 1 leaves the selector unchanged.
- R6: `rd_data` shows the running flag in bit 4 and the selector in bits [2:0]. All other bits read 0.
- R7: After reset the selector is 7, the timer is running and the lockout is clear, so `rd_data` = 0x17 and `wdt_rst_req` = 0.
- R8: On the edge that raises `wdt_rst_req`, the block returns to its reset state (selector 7, running, lockout clear).
- R9: A 0xA5 write captured on the same edge at which the count would expire restarts the count, and no request is raised.
- R10: A selector change does not alter the period already counting. It takes effect at the next restart.
- R11: While the timer is stopped, no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Byte written to the control register |
| rd_data | output | 8 | Register read value: bit 4 running, bits [2:0] selector |
| wdt_rst_req | output | 1 | One-clock reset request on expiry |

## Verification
Two events can meet on one clock edge: the count reaching its terminal value, and a restart write. The bench sets the shortest period and times a 0xA5 write so that it is captured on exactly the edge where expiry would fire. It then judges two things. No request may appear on that edge. The next request must come a full 64 clocks after the late restart.

// File: rtl/wdt_keyseq_pkg.sv
package wdt_keyseq_pkg;

    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int BASE_EXP = 3;
    localparam int WIN_CYC  = 4;
    localparam int STAT_BIT = 4;
    localparam int CFG_BIT  = 7;
    localparam int CNT_W    = 2 * (BASE_EXP + (1 << SEL_W) - 1);

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_OFF1 = 8'hDE;
    localparam logic [DATA_W-1:0] KEY_OFF2 = 8'hAD;
    localparam logic [DATA_W-1:0] KEY_LOCK = 8'hFF;

    typedef logic [SEL_W-1:0] ival_t;
    localparam ival_t IVAL_RST = '1;

    typedef struct packed {
        logic any;
        logic arm;
        logic off1;
        logic off2;
        logic lock;
        logic set_ival;
    } wcmd_t;

    // Terminal count for a selector: 4^(BASE_EXP+s) - 1
    function automatic logic [CNT_W-1:0] term_of(input ival_t s);
        logic [CNT_W:0] pow;
        pow = (CNT_W+1)'(1) << (2 * (BASE_EXP + int'(s)));
        return CNT_W'(pow - 1'b1);
    endfunction

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_keyseq_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wcmd_t             cmd
);
    always_comb begin
        cmd          = '0;
        cmd.any      = wr_en;
        cmd.arm      = wr_en && (wr_data == KEY_ARM);
        cmd.off1     = wr_en && (wr_data == KEY_OFF1);
        cmd.off2     = wr_en && (wr_data == KEY_OFF2);
        cmd.lock     = wr_en && (wr_data == KEY_LOCK);
        cmd.set_ival = wr_en && !wr_data[CFG_BIT];
    end
endmodule

// File: rtl/wdt_disarm_seq.sv
module wdt_disarm_seq
    import wdt_keyseq_pkg::*;
#(
    parameter int WIN = WIN_CYC
) (
    input  logic  clk,
    input  logic  srst,
    input  wcmd_t cmd,
    output logic  disarm,
    output logic  locked
);
    localparam int AGE_W = $clog2(WIN + 1);

    logic             pend;
    logic [AGE_W-1:0] age;

    assign disarm = cmd.off2 && pend && !locked;

    always_ff @(posedge clk) begin
        if (srst) begin
            pend   <= 1'b0;
            age    <= '0;
            locked <= 1'b0;
        end else begin
            if (cmd.lock)
                locked <= 1'b1;
            if (cmd.off1) begin
                pend <= 1'b1;
                age  <= AGE_W'(1);
            end else if (cmd.any) begin
                pend <= 1'b0;
            end else if (pend) begin
                if (age == AGE_W'(WIN))
                    pend <= 1'b0;
                else
                    age <= age + 1'b1;
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (srst)
        locked |=> locked); // R3
    AST_NO_DISARM_LOCKED: assert property (@(posedge clk) disable iff (srst)
        locked |-> !disarm); // R3
    AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (srst)
        pend |-> (age >= AGE_W'(1) && age <= AGE_W'(WIN))); // R2
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_keyseq_pkg::*;
(
    input  logic  clk,
    input  logic  srst,
    input  logic  reload,
    input  logic  disarm,
    input  ival_t ival,
    output logic  running,
    output logic  expire
);
    logic [CNT_W-1:0] cnt;
    ival_t            act_sel;
    logic [CNT_W-1:0] term;

    assign term   = term_of(act_sel);
    assign expire = running && (cnt == term) && !reload;

    always_ff @(posedge clk) begin
        if (srst) begin
            cnt     <= '0;
            running <= 1'b1;
            act_sel <= IVAL_RST;
        end else if (reload) begin
            cnt     <= '0;
            running <= 1'b1;
            act_sel <= ival;
        end else if (disarm) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (srst)
        reload |=> (cnt == '0 && running)); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (srst)
        running |-> (cnt <= term)); // R4
    AST_DISARM_STOP: assert property (@(posedge clk) disable iff (srst)
        disarm |=> !running); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (srst)
        (!running && !reload) |=> (!running && $stable(cnt))); // R11
endmodule

// File: rtl/wdt_keyseq_top.sv
module wdt_keyseq_top
    import wdt_keyseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_rst_req
);
    wcmd_t cmd;
    logic  disarm;
    logic  locked;
    logic  running;
    logic  expire;
    logic  soft_rst;
    ival_t ival;

    assign soft_rst = rst || expire;

    wdt_key_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    wdt_disarm_seq #(.WIN(WIN_CYC)) u_seq (
        .clk    (clk),
        .srst   (soft_rst),
        .cmd    (cmd),
        .disarm (disarm),
        .locked (locked)
    );

    wdt_timer u_tmr (
        .clk     (clk),
        .srst    (soft_rst),
        .reload  (cmd.arm),
        .disarm  (disarm),
        .ival    (ival),
        .running (running),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (soft_rst)
            ival <= IVAL_RST;
        else if (cmd.set_ival)
            ival <= wr_data[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            wdt_rst_req <= 1'b0;
        else
            wdt_rst_req <= expire;
    end

    always_comb begin
        rd_data                = '0;
        rd_data[STAT_BIT]      = running;
        rd_data[SEL_W-1:0]     = ival;
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |=> !wdt_rst_req); // R4
    AST_REQ_RESETS: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> (rd_data == 8'h17 && !locked)); // R8
    AST_IVAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[CFG_BIT] && !expire) |=> (ival == $past(ival))); // R5
    AST_RD_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7:5] == 3'b000 && rd_data[3] == 1'b0)); // R6
endmodule

// File: tb/test_wdt_keyseq_top.sv
module test_wdt_keyseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdt_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int req_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_keyseq_top i_wdt_keyseq_top (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .wdt_rst_req (wdt_rst_req)
    );

    always @(negedge clk) if (!rst && wdt_rst_req) req_seen++;

    // {write byte, expected read after it}
    localparam logic [15:0] VEC [12] = '{
        16'h02_12, 16'h80_12, 16'h00_10, 16'h33_13,
        16'hDE_13, 16'hAD_03, 16'hA5_13, 16'hDE_13,
        16'h05_15, 16'hAD_15, 16'h07_17, 16'hA5_17
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int start, input int exp, input string tag);
        int n = start;
        while (!wdt_rst_req && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n == exp, tag, n, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int base;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h17, "R7 reset read", rd_data, 8'h17);
        check(wdt_rst_req == 1'b0, "R7 reset req", wdt_rst_req, 0);

        wr(8'hAD);
        check(rd_data == 8'h17, "R2 lone second key", rd_data, 8'h17);

        // R5 R6 R2 R1 table walk
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][15:8]);
            check(rd_data == VEC[i][7:0], $sformatf("R5/R6 vector %0d", i), rd_data, VEC[i][7:0]);
        end

        // R2 window edges: gap 4 accepted, gap 5 ignored
        wr(8'hDE); idle(2); wr(8'hAD);
        check(rd_data == 8'h07, "R2 gap 4", rd_data, 8'h07);
        wr(8'hA5);
        check(rd_data == 8'h17, "R1 re-arm", rd_data, 8'h17);
        wr(8'hDE); idle(3); wr(8'hAD);
        check(rd_data == 8'h17, "R2 gap 5", rd_data, 8'h17);

        // R3 lockout
        wr(8'hFF);
        check(rd_data == 8'h17, "R3 lock write", rd_data, 8'h17);
        wr(8'hDE); wr(8'hAD);
        check(rd_data == 8'h17, "R3 disable blocked", rd_data, 8'h17);

        // R10 selector change mid-period does not shorten
        wr(8'h00);
        check(rd_data == 8'h10, "R5 selector 0", rd_data, 8'h10);
        base = req_seen;
        idle(300);
        check(req_seen == base, "R10 no early expiry", req_seen, base);

        // R4 period 64 and one-cycle pulse, R8 return to reset
        wr(8'hA5);
        measure(0, 64, "R4 period 64");
        check(rd_data == 8'h17, "R8 state after expiry", rd_data, 8'h17);
        @(negedge clk);
        check(wdt_rst_req == 1'b0, "R4 pulse width", wdt_rst_req, 0);
        check(req_seen == base + 1, "R4 single pulse", req_seen, base + 1);

        // R3 R8 lockout cleared by expiry
        wr(8'hDE); wr(8'hAD);
        check(rd_data == 8'h07, "R3 lock cleared", rd_data, 8'h07);
        wr(8'h00);
        base = req_seen;
        idle(300);
        check(req_seen == base, "R11 stopped no req", req_seen, base);
        check(rd_data == 8'h00, "R11 still stopped", rd_data, 8'h00);
        wr(8'hA5);
        check(rd_data == 8'h10, "R1 enable", rd_data, 8'h10);

        // R9 restart on the terminal edge
        idle(62);
        wr(8'hA5);
        check(req_seen == base, "R9 no req at collision", req_seen, base);
        measure(0, 64, "R9 full period after late restart");
        idle(1);

        // R3 lock byte does not restart
        wr(8'h00);
        wr(8'hA5);
        idle(20);
        wr(8'hFF);
        measure(22, 64, "R3 lock byte no reload");
        idle(1);

        done = 1'b1;
        finish_run();
    end
endmodule